// File: doc/BRIEF.md
# Clock-change sequencer for a CPU performance domain

This block moves a CPU clock domain from its present performance level to a newly requested one, entirely in hardware. A requester offers a 4-bit level on a valid/ready handshake. The block then writes the clock-divider configuration words, the PLL multiplier/pre-divider/post-divider word, the PLL lock-counter value and the core clock mux select. It waits on status inputs from the clock plant between steps. There are sixteen levels. Level 0 is the fastest at 1700 MHz, and each step up in index is 100 MHz slower, down to 200 MHz at level 15. All per-level settings come from constant tables inside the block.

The step order depends on direction. On a speed-up the dividers are reprogrammed before the PLL, so the core never runs fast with slow-domain ratios. On a slow-down the PLL goes first. The block compares the old and new {M,P} pair. When it differs, the core is parked on the alternate PLL while the main PLL relocks. When only the post-divider differs, a single PLL write replaces the S field and nothing else.

Every wait has a programmable cycle limit. Exceeding it raises a sticky error flag, puts the mux back on the main PLL and returns to idle with the recorded level unchanged.

Top module: `dvfs_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. While a sequence runs, `req_ready` stays low.
- R2: The first divider word holds eight 3-bit ratios, each in the low three bits of a nibble (field k at bit 4k). For each level the fields are: 0, core-peripheral ratio (3,3,2,2,2,2,3 for levels 0..6, then 1), 7, 7, trace ratio (7,7,7,6,6,5,5,4,4,4,3,3,2,2,1,1), debug ratio (3 at level 0, else 1), PLL-output ratio (5,4,4,4,3,3,3,2,2,2,1,1,1,1,1,1), 0. The second word is 0x20 (ratio 0 at bit 0, ratio 2 at bit 4).
- R3: The PLL word carries M in bits 25:16, P in bits 13:8 and S in bits 2:0, and all other bits are zero. Per level, M is 425,200,250,175,325,200,275,125,150,100,175,200,125,100,200,100. P is 6,3,4,3,6,4,6,3,4,3,3,4,3,3,4,3. S is 0 for levels 0..9, 1 for 10..13 and 2 for 14..15. When old and new {M,P} are equal, the PLL is written once with only S changed, with no lock-counter load and no mux change.
- R4: A divider update writes the first word, waits until all eight busy inputs are low, then writes the second word and waits until both of its busy inputs are low.
- R5: `done` pulses for one cycle when a sequence finishes. `cur_lvl` takes the new level in that same cycle and never changes otherwise.
- R6: A relock runs in order: mux to alternate (`mux_sel`=1) and wait for `mux_stat`==2; load `lock_cnt` with P×250; write the PLL word; wait for `pll_locked`; mux back to main (`mux_sel`=0) and wait for `mux_stat`==1.
- R7: If the new index is below the old, the divider update runs before the PLL step. Otherwise the PLL step runs first.
- R8: A wait longer than `timeout_lim` cycles sets `err`. `err` stays set until reset. The block then drives the mux to main and returns to idle, with no `done` and `cur_lvl` unchanged.
- R9: A request for the current level causes no write strobe and no mux change, and pulses `done` one cycle after acceptance.
- R10: After reset the block is idle, with `req_ready`=1, `cur_lvl`=RESET_LVL (default 9), `mux_sel`=0, `err`=0, `done`=0, and the PLL and divider words of that level on their outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Level request valid |
| req_lvl | input | 4 | Requested level index |
| req_ready | output | 1 | Block idle, request can be taken |
| timeout_lim | input | TW | Wait limit in cycles |
| div0_word | output | 32 | First divider configuration word |
| div0_we | output | 1 | Write strobe for first divider word |
| div0_busy | input | 8 | Busy flags for first divider word |
| div1_word | output | 32 | Second divider configuration word |
| div1_we | output | 1 | Write strobe for second divider word |
| div1_busy | input | 2 | Busy flags for second divider word |
| pll_cfg | output | 32 | PLL M/P/S configuration word |
| pll_we | output | 1 | Write strobe for PLL word |
| lock_cnt | output | 16 | PLL lock counter value |
| lock_we | output | 1 | Write strobe for lock counter |
| pll_locked | input | 1 | PLL lock flag |
| mux_sel | output | 1 | Core mux select, 0 main PLL, 1 alternate |
| mux_stat | input | 3 | Mux status, 1 main active, 2 alternate active |
| done | output | 1 | Sequence finished pulse |
| err | output | 1 | Sticky timeout error |
| cur_lvl | output | 4 | Level currently applied |

## Verification
A wrong internal state shows up at the ports as a strobe or mux edge out of order, or a missing one, and the bench sees this within the request that caused it. A wrongly taken relock or S-only decision shows as the presence or absence of a lock-counter load and mux swings. A wrong table entry shows in the word written. The bench logs every strobe and mux edge of each request as an ordered signature and compares it with one derived from the level pair. A stuck or skipped wait shows either as a timeout with `err` or as the second divider write coming fewer cycles after the first than the busy window allows.

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int RESET_LVL = 9,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_lvl,
  output logic          req_ready,
  input  logic [TW-1:0] timeout_lim,
  output logic [31:0]   div0_word,
  output logic          div0_we,
  input  logic [7:0]    div0_busy,
  output logic [31:0]   div1_word,
  output logic          div1_we,
  input  logic [1:0]    div1_busy,
  output logic [31:0]   pll_cfg,
  output logic          pll_we,
  output logic [15:0]   lock_cnt,
  output logic          lock_we,
  input  logic          pll_locked,
  output logic          mux_sel,
  input  logic [2:0]    mux_stat,
  output logic          done,
  output logic          err,
  output logic [3:0]    cur_lvl
);

  localparam logic [3:0] RST_L = 4'(RESET_LVL);
  localparam logic [31:0] DIV1_W = 32'h0000_0020;

  typedef enum logic [3:0] {
    IDLE, D0W, D0T, D1W, D1T, SW, MA, MAT, LKW, PW, LKT, MM, MMT
  } st_t;

  function automatic logic [18:0] pms(input logic [3:0] l);
    case (l)
      4'd0:  pms = {10'd425, 6'd6, 3'd0};
      4'd1:  pms = {10'd200, 6'd3, 3'd0};
      4'd2:  pms = {10'd250, 6'd4, 3'd0};
      4'd3:  pms = {10'd175, 6'd3, 3'd0};
      4'd4:  pms = {10'd325, 6'd6, 3'd0};
      4'd5:  pms = {10'd200, 6'd4, 3'd0};
      4'd6:  pms = {10'd275, 6'd6, 3'd0};
      4'd7:  pms = {10'd125, 6'd3, 3'd0};
      4'd8:  pms = {10'd150, 6'd4, 3'd0};
      4'd9:  pms = {10'd100, 6'd3, 3'd0};
      4'd10: pms = {10'd175, 6'd3, 3'd1};
      4'd11: pms = {10'd200, 6'd4, 3'd1};
      4'd12: pms = {10'd125, 6'd3, 3'd1};
      4'd13: pms = {10'd100, 6'd3, 3'd1};
      4'd14: pms = {10'd200, 6'd4, 3'd2};
      default: pms = {10'd100, 6'd3, 3'd2};
    endcase
  endfunction

  function automatic logic [31:0] pword(input logic [3:0] l);
    logic [18:0] v;
    v = pms(l);
    pword = {6'd0, v[18:9], 2'd0, v[8:3], 5'd0, v[2:0]};
  endfunction

  function automatic logic [31:0] dword(input logic [3:0] l);
    logic [2:0] cpd, trc, dbg, apl;
    cpd = (l == 4'd0 || l == 4'd1 || l == 4'd6) ? 3'd3 : (l <= 4'd5) ? 3'd2 : 3'd1;
    trc = (l <= 4'd2) ? 3'd7 : (l <= 4'd4) ? 3'd6 : (l <= 4'd6) ? 3'd5 :
          (l <= 4'd9) ? 3'd4 : (l <= 4'd11) ? 3'd3 : (l <= 4'd13) ? 3'd2 : 3'd1;
    dbg = (l == 4'd0) ? 3'd3 : 3'd1;
    apl = (l == 4'd0) ? 3'd5 : (l <= 4'd3) ? 3'd4 : (l <= 4'd6) ? 3'd3 :
          (l <= 4'd9) ? 3'd2 : 3'd1;
    dword = {5'd0, apl, 1'b0, dbg, 1'b0, trc, 8'h77, 1'b0, cpd, 4'd0};
  endfunction

  st_t st;
  logic [3:0] tgt;
  logic faster, relock, second;
  logic [TW-1:0] cnt;
  logic cond;

  wire relock_now = pms(req_lvl)[18:3] != pms(cur_lvl)[18:3];
  wire waiting = st inside {D0T, D1T, MAT, LKT, MMT};

  always_comb
    case (st)
      D0T:     cond = div0_busy == '0;
      D1T:     cond = div1_busy == '0;
      MAT:     cond = mux_stat == 3'd2;
      LKT:     cond = pll_locked;
      MMT:     cond = mux_stat == 3'd1;
      default: cond = 1'b0;
    endcase

  wire go  = waiting && cnt != '0 && cond;
  wire tmo = waiting && !go && cnt != '0 && cnt >= timeout_lim;
  wire phase_end = (st == SW) || (go && (st == D1T || st == MMT));

  assign req_ready = st == IDLE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; tgt <= RST_L; faster <= 1'b0; relock <= 1'b0; second <= 1'b0;
      cnt <= '0; cur_lvl <= RST_L; done <= 1'b0; err <= 1'b0; mux_sel <= 1'b0;
      div0_word <= dword(RST_L); div1_word <= DIV1_W; pll_cfg <= pword(RST_L);
      lock_cnt <= '0; div0_we <= 1'b0; div1_we <= 1'b0; pll_we <= 1'b0; lock_we <= 1'b0;
    end else begin
      div0_we <= 1'b0; div1_we <= 1'b0; pll_we <= 1'b0; lock_we <= 1'b0; done <= 1'b0;
      cnt <= (waiting && !go && !tmo) ? cnt + 1'b1 : '0;
      case (st)
        IDLE: if (req_valid) begin
          if (req_lvl == cur_lvl) done <= 1'b1;
          else begin
            tgt <= req_lvl;
            faster <= req_lvl < cur_lvl;
            relock <= relock_now;
            second <= 1'b0;
            st <= (req_lvl < cur_lvl) ? D0W : (relock_now ? MA : SW);
          end
        end
        D0W: begin div0_word <= dword(tgt); div0_we <= 1'b1; st <= D0T; end
        D0T: if (go) st <= D1W;
        D1W: begin div1_word <= DIV1_W; div1_we <= 1'b1; st <= D1T; end
        SW:  begin pll_cfg <= {pll_cfg[31:3], pms(tgt)[2:0]}; pll_we <= 1'b1; end
        MA:  begin mux_sel <= 1'b1; st <= MAT; end
        MAT: if (go) st <= LKW;
        LKW: begin lock_cnt <= 16'(pms(tgt)[8:3]) * 16'd250; lock_we <= 1'b1; st <= PW; end
        PW:  begin pll_cfg <= pword(tgt); pll_we <= 1'b1; st <= LKT; end
        LKT: if (go) st <= MM;
        MM:  begin mux_sel <= 1'b0; st <= MMT; end
        default: ;
      endcase
      if (phase_end) begin
        if (!second) begin
          second <= 1'b1;
          st <= faster ? (relock ? MA : SW) : D0W;
        end else begin
          cur_lvl <= tgt; done <= 1'b1; st <= IDLE;
        end
      end
      if (tmo) begin err <= 1'b1; mux_sel <= 1'b0; st <= IDLE; end
    end

endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       div0_we,
  input logic       div1_we,
  input logic       pll_we,
  input logic       lock_we,
  input logic [7:0] div0_busy,
  input logic       mux_sel,
  input logic       done,
  input logic       err,
  input logic [3:0] cur_lvl
);

  a_r5_lvl_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl != $past(cur_lvl)) |-> done);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r6_lock_on_alt: assert property (@(posedge clk) disable iff (!rst_n)
    lock_we |-> mux_sel);

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div0_we, div1_we, pll_we, lock_we}));

  a_r4_div1_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    div1_we |-> (div0_busy == 8'd0));

endmodule

bind dvfs_seq dvfs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div0_we(div0_we), .div1_we(div1_we),
  .pll_we(pll_we), .lock_we(lock_we), .div0_busy(div0_busy),
  .mux_sel(mux_sel), .done(done), .err(err), .cur_lvl(cur_lvl)
);

// File: tb/dvfs_seq_tb.sv
`timescale 1ns/1ps
module dvfs_seq_tb;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_lvl = 4'd0;
  logic req_ready;
  logic [15:0] timeout_lim = 16'd200;
  logic [31:0] div0_word, div1_word, pll_cfg;
  logic div0_we, div1_we, pll_we, lock_we;
  logic [7:0] div0_busy = 8'd0;
  logic [1:0] div1_busy = 2'd0;
  logic [15:0] lock_cnt;
  logic pll_locked = 1'b1;
  logic mux_sel;
  logic [2:0] mux_stat = 3'd1;
  logic done, err;
  logic [3:0] cur_lvl;

  always #2.5 clk = ~clk;

  dvfs_seq u_dut (.*);

  localparam int MV[16] = '{425,200,250,175,325,200,275,125,150,100,175,200,125,100,200,100};
  localparam int PV[16] = '{6,3,4,3,6,4,6,3,4,3,3,4,3,3,4,3};
  localparam int SV[16] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,1,2,2};
  localparam int CPV[16] = '{3,3,2,2,2,2,3,1,1,1,1,1,1,1,1,1};
  localparam int TRV[16] = '{7,7,7,6,6,5,5,4,4,4,3,3,2,2,1,1};
  localparam int APV[16] = '{5,4,4,4,3,3,3,2,2,2,1,1,1,1,1,1};
  localparam logic [3:0] VEC[9] = '{4'd7, 4'd12, 4'd7, 4'd0, 4'd15, 4'd13, 4'd13, 4'd3, 4'd10};

  int n_chk = 0, n_bad = 0;
  int cyc = 0, t_d0 = 0, t_d1 = 0, nev = 0;
  logic [31:0] sig = 0;
  int b0 = 0, b1 = 0, lk = 0, mc = 0;
  logic msel_q = 1'b0;
  bit hang_mux = 1'b0, finished = 1'b0;

  function automatic logic [31:0] e_pll(int l);
    return (32'(MV[l]) << 16) | (32'(PV[l]) << 8) | 32'(SV[l]);
  endfunction
  function automatic logic [31:0] e_div0(int l);
    return (32'(APV[l]) << 24) | (32'(l == 0 ? 3 : 1) << 20) | (32'(TRV[l]) << 16) |
           32'h0000_7700 | (32'(CPV[l]) << 4);
  endfunction
  function automatic bit e_rl(int a, int b);
    return MV[a] != MV[b] || PV[a] != PV[b];
  endfunction
  function automatic logic [31:0] e_sig(int o, int n);
    logic [31:0] dv, pl;
    int pn;
    if (o == n) return 0;
    dv = 32'h12;
    pl = e_rl(o, n) ? 32'h5346 : 32'h4;
    pn = e_rl(o, n) ? 4 : 1;
    if (n < o) return (dv << (4 * pn)) | pl;
    return (pl << 8) | dv;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (div0_we) begin b0 = 3; t_d0 = cyc; sig = {sig[27:0], 4'h1}; nev++; end
    else if (b0 != 0) b0--;
    div0_busy = (b0 != 0) ? 8'hA5 : 8'h00;
    if (div1_we) begin b1 = 2; t_d1 = cyc; sig = {sig[27:0], 4'h2}; nev++; end
    else if (b1 != 0) b1--;
    div1_busy = (b1 != 0) ? 2'b11 : 2'b00;
    if (lock_we) begin sig = {sig[27:0], 4'h3}; nev++; end
    if (pll_we) begin sig = {sig[27:0], 4'h4}; nev++; lk = 5; pll_locked = 1'b0; end
    else if (lk != 0) begin lk--; if (lk == 0) pll_locked = 1'b1; end
    if (mux_sel != msel_q) begin
      sig = {sig[27:0], mux_sel ? 4'h5 : 4'h6}; nev++;
      msel_q = mux_sel; mc = 2; mux_stat = 3'd0;
    end else if (mc != 0) begin
      mc--;
      if (mc == 0 && !(hang_mux && msel_q)) mux_stat = msel_q ? 3'd2 : 3'd1;
    end
  end

  task automatic request(input logic [3:0] lvl, output bit got, output bit rdy_mid,
                         output logic [3:0] lvl_mid);
    @(negedge clk);
    sig = 0; nev = 0;
    req_valid = 1'b1; req_lvl = lvl;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_mid = req_ready; lvl_mid = cur_lvl;
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      if (done) got = 1'b1;
      else if (req_ready && i > 0) i = 3000;
      else @(negedge clk);
    end
    #1;
  endtask

  initial begin
    bit got, rdy;
    logic [3:0] lm;
    int cur;
    cur = 9;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done && !err && !mux_sel, "R10 idle flags", {req_ready, done, err, mux_sel}, 4'b1000);
    check(cur_lvl == 4'd9, "R10 reset level", cur_lvl, 9);
    check(pll_cfg == e_pll(9), "R10 reset pll word", pll_cfg, e_pll(9));
    check(div0_word == e_div0(9), "R10 reset div word", div0_word, e_div0(9));

    foreach (VEC[k]) begin
      int n;
      n = VEC[k];
      request(VEC[k], got, rdy, lm);
      check(got, "R5 done seen", got, 1);
      check(sig == e_sig(cur, n), cur == n ? "R9 no writes" : "R7 step order", sig, e_sig(cur, n));
      if (cur != n) begin
        check(!rdy, "R1 ready low while busy", rdy, 0);
        check(lm == 4'(cur), "R5 level held mid-sequence", lm, cur);
        check(pll_cfg == e_pll(n), "R3 pll word", pll_cfg, e_pll(n));
        check(div0_word == e_div0(n), "R2 divider word", div0_word, e_div0(n));
        check(div1_word == 32'h20, "R4 second divider word", div1_word, 32'h20);
        check(t_d1 - t_d0 >= 4, "R4 busy wait gap", t_d1 - t_d0, 4);
        if (e_rl(cur, n))
          check(lock_cnt == 16'(PV[n] * 250), "R6 lock count", lock_cnt, PV[n] * 250);
        check(!mux_sel && mux_stat == 3'd1, "R6 mux back on main", mux_sel, 0);
      end else begin
        check(nev == 0 && rdy, "R9 same level idle", nev, 0);
      end
      check(cur_lvl == 4'(n), "R5 level at done", cur_lvl, n);
      @(negedge clk);
      check(!done, "R5 done one cycle", done, 0);
      check(req_ready, "R1 ready after done", req_ready, 1);
      cur = n;
    end

    timeout_lim = 16'd20;
    hang_mux = 1'b1;
    request(4'd0, got, rdy, lm);
    check(!got, "R8 no done on timeout", got, 0);
    check(err, "R8 err set", err, 1);
    check(cur_lvl == 4'(cur), "R8 level kept", cur_lvl, cur);
    check(!mux_sel && req_ready, "R8 mux main and idle", {mux_sel, req_ready}, 2'b01);
    hang_mux = 1'b0;
    repeat (5) @(negedge clk);
    timeout_lim = 16'd200;
    request(4'd0, got, rdy, lm);
    check(got && cur_lvl == 4'd0, "R6 relock after timeout", cur_lvl, 0);
    check(sig == e_sig(cur, 0), "R7 faster relock order", sig, e_sig(cur, 0));
    check(err, "R8 err sticky", err, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule